// File: doc/BRIEF.md
# Lookup-Table Single-Precision Divider

This block divides one IEEE 754 single-precision value by another without an iterative divider. Both operands are taken as normalised significands in [1, 2). The top K fraction bits of the dividend and the top K fraction bits of the divisor select one entry of a ratio table. The quotient sign and exponent come from separate small paths, and the result is then packed into a single-precision word. Operands whose exponent field is zero are treated as zero. NaN, denormals and correct rounding are not handled.

Every table entry holds the ratio of the centre points of the two selected significand cells. It is stored with 24 fraction bits, and the table is built at elaboration from the parameter K. The table has 2^(2K) entries, so K sets both its size and the accuracy of the quotient. Operands enter with a valid strobe. The result leaves two clock cycles later with its own strobe and two exception flags. A new operand pair can be accepted on every cycle.

Top module: `tbl_fdiv`

## Requirements
- R1: `out_valid` is high for exactly one cycle, two rising edges after each cycle in which `in_valid` is high. Operand pairs on consecutive cycles give results on consecutive cycles.
- R2: The quotient sign bit (bit 31) is the XOR of the two operand sign bits. This holds for every result, including zero and infinity results.
- R3: When the table ratio is at least 1, the biased result exponent is dividend exponent − divisor exponent + 127. Operands with equal top-K fraction bits give an exact result. For example, 6.0 / 3.0 gives 0x40000000.
- R4: When the table ratio is below 1, the significand is renormalised by one position and the biased exponent is one less than in R3. For example, 1.0 / 1.5 gives exponent field 126.
- R5: The table index is {dividend fraction[22:23−K], divisor fraction[22:23−K]}. An entry holds the ratio of the centre points of the two cells. For a normal result, the relative error is at most 2δ/(1−δ) + 2^-22, where δ = 2^-(K+1).
- R6: A dividend with exponent field 0 and a non-zero divisor raises `zero_flag` and gives a zero with the sign from R2.
- R7: A divisor with exponent field 0 raises `inf_flag` and gives exponent field 255 with a zero fraction, signed as in R2. When both operands are zero, only `inf_flag` is raised.
- R8: A biased result exponent of 255 or more gives a signed infinity (0x7F800000 or 0xFF800000), with both flags low. An exponent of 254 stays a normal result.
- R9: A biased result exponent of 0 or less gives a signed zero, with both flags low. An exponent of 1 stays a normal result.
- R10: While reset is high and after it is released, `out_valid`, `quotient`, `zero_flag` and `inf_flag` are all 0.
- R11: `quotient`, `zero_flag` and `inf_flag` keep their last values in cycles where `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair is present |
| dividend | input | 32 | Single-precision dividend |
| divisor | input | 32 | Single-precision divisor |
| out_valid | output | 1 | Result strobe |
| quotient | output | 32 | Single-precision quotient |
| zero_flag | output | 1 | Dividend was zero |
| inf_flag | output | 1 | Divisor was zero |

## Verification
Operand pairs whose top fraction bits fall in the same cell give exact powers of two. These separate the exponent arithmetic and the sign path from the table contents. Pairs in different cells, including a ratio below 1, and a long pseudo-random sweep over signs, exponents and fractions are checked against the K-dependent error bound. These catch a wrong table entry or a wrong renormalisation step. Zero operands and exponents placed exactly at 0, 1, 254 and 255 separate the exception priority from the saturation and flush paths.

// File: rtl/tfd_pkg.sv
package tfd_pkg;

    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int BIAS   = 127;
    localparam int RAT_W  = FRAC_W + 2;   // ratio in [0.5, 2) with 24 fraction bits
    localparam int EXR_W  = EXP_W + 2;    // signed raw exponent

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [FRAC_W-1:0] frac;
    } sp_t;

    typedef struct packed {
        logic                    sgn;
        logic signed [EXR_W-1:0] exp_raw;
        logic                    a_zero;
        logic                    b_zero;
    } s1_t;

    // centre-point ratio of dividend cell i and divisor cell j, k index bits
    function automatic logic [RAT_W-1:0] mid_ratio(input int i, input int j, input int k);
        longint n;
        longint d;
        n = (64'sd1 <<< (k + 1)) + 64'(2 * i + 1);
        d = (64'sd1 <<< (k + 1)) + 64'(2 * j + 1);
        return RAT_W'((n <<< (FRAC_W + 1)) / d);
    endfunction

endpackage

// File: rtl/tfd_unpack.sv
module tfd_unpack
    import tfd_pkg::*;
#(
    parameter int K = 4
) (
    input  logic [31:0]    a_bits,
    input  logic [31:0]    b_bits,
    output s1_t            info,
    output logic [2*K-1:0] idx
);
    sp_t a, b;

    always_comb begin
        a = sp_t'(a_bits);
        b = sp_t'(b_bits);
        info.sgn     = a.sign ^ b.sign;
        info.a_zero  = (a.exp == '0);
        info.b_zero  = (b.exp == '0);
        info.exp_raw = $signed({2'b00, a.exp}) - $signed({2'b00, b.exp})
                     + EXR_W'(BIAS);
        idx          = {a.frac[FRAC_W-1 -: K], b.frac[FRAC_W-1 -: K]};
    end
endmodule

// File: rtl/tfd_ratio_rom.sv
module tfd_ratio_rom
    import tfd_pkg::*;
#(
    parameter int K = 4
) (
    input  logic [2*K-1:0]   idx,
    output logic [RAT_W-1:0] ratio
);
    localparam int N    = 1 << (2 * K);
    localparam int CELL = 1 << K;

    logic [RAT_W-1:0] tbl [N];

    for (genvar g = 0; g < N; g++) begin : g_ent
        localparam logic [RAT_W-1:0] ENT = mid_ratio(g / CELL, g % CELL, K);
        assign tbl[g] = ENT;
    end

    assign ratio = tbl[idx];
endmodule

// File: rtl/tfd_pack.sv
module tfd_pack
    import tfd_pkg::*;
(
    input  s1_t              info,
    input  logic [RAT_W-1:0] ratio,
    output logic [31:0]      q_bits,
    output logic             zf,
    output logic             inf
);
    logic                    hi;
    logic [FRAC_W-1:0]       mant;
    logic signed [EXR_W-1:0] e;
    sp_t                     q;

    always_comb begin
        hi   = ratio[RAT_W-1];
        mant = hi ? ratio[FRAC_W:1] : ratio[FRAC_W-1:0];
        e    = info.exp_raw - (hi ? EXR_W'(0) : EXR_W'(1));
        zf   = 1'b0;
        inf  = 1'b0;
        q.sign = info.sgn;
        q.exp  = '0;
        q.frac = '0;
        if (info.b_zero) begin
            inf   = 1'b1;
            q.exp = '1;
        end else if (info.a_zero) begin
            zf = 1'b1;
        end else if (e >= EXR_W'(255)) begin
            q.exp = '1;
        end else if (e > EXR_W'(0)) begin
            q.exp  = e[EXP_W-1:0];
            q.frac = mant;
        end
        q_bits = q;
    end
endmodule

// File: rtl/tbl_fdiv.sv
module tbl_fdiv
    import tfd_pkg::*;
#(
    parameter int K = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] dividend,
    input  logic [31:0] divisor,
    output logic        out_valid,
    output logic [31:0] quotient,
    output logic        zero_flag,
    output logic        inf_flag
);
    s1_t              info_c, info_r;
    logic [2*K-1:0]   idx_c;
    logic [RAT_W-1:0] ratio_c, ratio_r;
    logic             v_r;
    logic [31:0]      q_c;
    logic             zf_c, inf_c;

    tfd_unpack #(.K(K)) u_unpack (
        .a_bits(dividend), .b_bits(divisor), .info(info_c), .idx(idx_c)
    );

    tfd_ratio_rom #(.K(K)) u_rom (.idx(idx_c), .ratio(ratio_c));

    always_ff @(posedge clk) begin
        if (rst) begin
            v_r     <= 1'b0;
            info_r  <= '0;
            ratio_r <= '0;
        end else begin
            v_r <= in_valid;
            if (in_valid) begin
                info_r  <= info_c;
                ratio_r <= ratio_c;
            end
        end
    end

    tfd_pack u_pack (
        .info(info_r), .ratio(ratio_r), .q_bits(q_c), .zf(zf_c), .inf(inf_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            quotient  <= '0;
            zero_flag <= 1'b0;
            inf_flag  <= 1'b0;
        end else begin
            out_valid <= v_r;
            if (v_r) begin
                quotient  <= q_c;
                zero_flag <= zf_c;
                inf_flag  <= inf_c;
            end
        end
    end
endmodule

// File: rtl/tfd_chk.sv
module tfd_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] dividend,
    input logic [31:0] divisor,
    input logic        out_valid,
    input logic [31:0] quotient,
    input logic        zero_flag,
    input logic        inf_flag
);
    logic [1:0] vq;

    always_ff @(posedge clk) begin
        if (rst) vq <= '0;
        else     vq <= {vq[0], in_valid};
    end

    // R1
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == vq[1]);

    // R2
    sign_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> quotient[31] == ($past(dividend[31], 2) ^ $past(divisor[31], 2)));

    // R7
    inf_pattern_chk: assert property (@(posedge clk) disable iff (rst)
        inf_flag |-> (quotient[30:0] == {8'hFF, 23'd0}) && !zero_flag);

    // R6
    zero_pattern_chk: assert property (@(posedge clk) disable iff (rst)
        zero_flag |-> quotient[30:0] == 31'd0);

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(quotient) && $stable(zero_flag) && $stable(inf_flag));
endmodule

bind tbl_fdiv tfd_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .dividend(dividend),
    .divisor(divisor), .out_valid(out_valid), .quotient(quotient),
    .zero_flag(zero_flag), .inf_flag(inf_flag)
);

// File: tb/sim_tbl_fdiv.sv
`timescale 1ns/1ps
module sim_tbl_fdiv;
    localparam int K  = 4;
    localparam int NV = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic        out_valid;
    logic [31:0] quotient;
    logic        zero_flag, inf_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    tbl_fdiv #(.K(K)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .dividend(dividend),
        .divisor(divisor), .out_valid(out_valid), .quotient(quotient),
        .zero_flag(zero_flag), .inf_flag(inf_flag)
    );

    // mode 0: exact word, 1: error bound, 2: error bound + exponent field
    localparam logic [31:0] VA [NV] = '{
        32'h40000000, 32'h40C00000, 32'hC1000000, 32'h3F800000,
        32'h40490FDB, 32'h00000000, 32'h80000000, 32'h40000000,
        32'hC0000000, 32'h00000000, 32'h7F000000, 32'h00800000,
        32'h80800000, 32'h3F800000, 32'h7F000000, 32'h7F000000};
    localparam logic [31:0] VB [NV] = '{
        32'h3F800000, 32'h40400000, 32'h40000000, 32'h3FC00000,
        32'h402DF854, 32'h40000000, 32'h40000000, 32'h00000000,
        32'h00000000, 32'h80000000, 32'h00800000, 32'h7F000000,
        32'h3F800000, 32'h7F000000, 32'h3F000000, 32'h3F800000};
    localparam logic [31:0] VQ [NV] = '{
        32'h40000000, 32'h40000000, 32'hC0800000, 32'h3F000000,
        32'h0,        32'h00000000, 32'h80000000, 32'h7F800000,
        32'hFF800000, 32'hFF800000, 32'h7F800000, 32'h00000000,
        32'h80800000, 32'h00000000, 32'h7F800000, 32'h7F000000};
    localparam logic [1:0] VF [NV] = '{   // {inf, zero}
        2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b01, 2'b01, 2'b10,
        2'b10, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00};
    localparam int VM [NV] = '{0, 0, 0, 2, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    localparam string VR [NV] = '{
        "R3", "R3", "R2", "R4", "R5", "R6", "R6", "R7",
        "R7", "R7", "R8", "R9", "R9", "R9", "R8", "R8"};

    function automatic real sp2r(input logic [31:0] x);
        real m;
        int  e;
        if (x[30:23] == 8'd0) return 0.0;
        m = 1.0 + real'(x[22:0]) / 8388608.0;
        e = int'(x[30:23]) - 127;
        for (int i = 0; i < e; i++)  m = m * 2.0;
        for (int i = 0; i > e; i--)  m = m / 2.0;
        return x[31] ? -m : m;
    endfunction

    function automatic real err_bound();
        real dl;
        dl = 1.0;
        for (int i = 0; i < K + 1; i++) dl = dl / 2.0;
        return 2.0 * dl / (1.0 - dl) + 1.0 / 4194304.0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // drive one pair, sample the result two edges later
    task automatic run(input logic [31:0] a, input logic [31:0] b, input string req);
        @(negedge clk);
        dividend = a; divisor = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R1", 32'(out_valid), 32'd0);
        @(negedge clk);
        check(out_valid == 1'b1, "R1", 32'(out_valid), 32'd1);
    endtask

    task automatic check_bound(input logic [31:0] a, input logic [31:0] b,
                               input string req);
        real tv, av, rel;
        tv  = sp2r(a) / sp2r(b);
        av  = sp2r(quotient);
        rel = (av - tv) / tv;
        if (rel < 0.0) rel = -rel;
        check(rel <= err_bound(), req, quotient, 32'(a ^ b) & 32'h80000000);
        check(quotient[31] == (a[31] ^ b[31]), "R2", 32'(quotient[31]),
              32'(a[31] ^ b[31]));
        check({inf_flag, zero_flag} == 2'b00, req, 32'({inf_flag, zero_flag}), 32'd0);
    endtask

    initial begin : main
        logic [31:0] st, a, b, held;
        repeat (3) @(negedge clk);
        // R10: during reset
        check(out_valid == 0 && quotient == 0 && !zero_flag && !inf_flag, "R10",
              quotient, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 0 && quotient == 0 && !zero_flag && !inf_flag, "R10",
              quotient, 32'd0);

        for (int v = 0; v < NV; v++) begin
            run(VA[v], VB[v], VR[v]);
            if (VM[v] == 0) begin
                check(quotient == VQ[v], VR[v], quotient, VQ[v]);
                check({inf_flag, zero_flag} == VF[v], VR[v],
                      32'({inf_flag, zero_flag}), 32'(VF[v]));
            end else begin
                check_bound(VA[v], VB[v], VR[v]);
                if (VM[v] == 2)
                    check(quotient[30:23] == VQ[v][30:23], VR[v],
                          32'(quotient[30:23]), 32'(VQ[v][30:23]));
            end
        end

        // R11: outputs hold while out_valid is low
        held = quotient;
        repeat (4) @(negedge clk);
        check(quotient == held && out_valid == 0 && !zero_flag && !inf_flag, "R11",
              quotient, held);

        // R1: back-to-back pairs, R3 exact results
        @(negedge clk);
        dividend = 32'h40800000; divisor = 32'h3F800000; in_valid = 1'b1;
        @(negedge clk);
        dividend = 32'hBF800000; divisor = 32'h40000000;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && quotient == 32'h40800000, "R1", quotient, 32'h40800000);
        @(negedge clk);
        check(out_valid && quotient == 32'hBF000000, "R1", quotient, 32'hBF000000);
        @(negedge clk);
        check(out_valid == 1'b0, "R1", 32'(out_valid), 32'd0);

        // R5: pseudo-random sweep of normal operands
        st = 32'h1234ABCD;
        for (int n = 0; n < 300; n++) begin
            st = st * 32'd1664525 + 32'd1013904223;
            a  = {st[0], 8'(100 + int'(st[15:8]) % 50), st[31:9]};
            st = st * 32'd1664525 + 32'd1013904223;
            b  = {st[0], 8'(100 + int'(st[15:8]) % 50), st[31:9]};
            run(a, b, "R5");
            check_bound(a, b, "R5");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule